// File: doc/BRIEF.md
# Differential Clock Stop and Power-Down Gate

This block sits between a clock source and a set of differential output pairs (true and complement) and decides, per pair, whether the pair toggles, is parked at a fixed level, or has both drivers switched off. The pairs form two groups. The processor group answers to an active-low processor stop pin. The peripheral group answers to an active-low peripheral-bus stop pin. A shared active-low power-down pin affects both groups. Each pair has an enable bit and a free-run bit. A free-running pair ignores its group's stop pin and answers only to power-down.

For each group, one mode bit picks what happens to stopped pairs and another picks what happens to powered-down pairs. Each bit selects either parked (true high, complement low) or tristate. When power-down is released, a resume window of a parameterised number of reference cycles must pass before any pair restarts. During that window the stop pins are still sampled, and changes to the mode, enable and free-run bits are held back. All of them take effect together when the window closes. The pins pass through two-flop synchronizers. The output clock is the reference divided by two, and a pair changes state only on the edge where its true line would rise, so no shortened pulse can occur.

Top module: `clk_stop_gate`

## Requirements
- R1: While reset is high, every pair reports state 2'b10 (tristate) with its drive enable low.
- R2: A running pair reports state 2'b00, drives its enable high, toggles its true line on every reference cycle, and keeps its complement line the inverse of the true line.
- R3: A pair whose enable bit is 0 reports state 2'b10, with true, complement and drive enable all low.
- R4: While its group's stop pin is low and the group's stop-mode bit is 0 (parked), a pair that is not free-running reports state 2'b01 with true high and complement low. A free-running pair keeps running.
- R5: While its group's stop pin is low and the group's stop-mode bit is 1, a pair that is not free-running reports state 2'b10.
- R6: The processor stop pin affects only pairs 0 to N_CPU-1. The peripheral stop pin affects only pairs N_CPU and above.
- R7: While power-down is low, every enabled pair, free-running pairs included, reports 2'b01 if its group's power-down-mode bit is 0 and 2'b10 if that bit is 1, whatever the stop pins show.
- R8: After power-down goes high, the pairs hold their power-down state for at least RESUME_CYC reference cycles, and all of them leave it within RESUME_CYC+6 cycles.
- R9: A stop-pin release, enable-bit change or mode-bit change made inside the resume window has no effect until the window closes, and takes effect when it does.
- R10: A pair's state changes only on the edge where its true line goes high.
- R11: A stoppable pair reaches its stopped state no later than four reference cycles after its stop pin falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_stop_n | input | 1 | Processor-group stop request, active low, asynchronous |
| pci_stop_n | input | 1 | Peripheral-group stop request, active low, asynchronous |
| pwrdn_n | input | 1 | Global power-down request, active low, asynchronous |
| cpu_stop_tri | input | 1 | Processor group: stopped pairs tristate (1) or parked (0) |
| cpu_pd_tri | input | 1 | Processor group: powered-down pairs tristate (1) or parked (0) |
| src_stop_tri | input | 1 | Peripheral group: stopped pairs tristate (1) or parked (0) |
| src_pd_tri | input | 1 | Peripheral group: powered-down pairs tristate (1) or parked (0) |
| out_oe | input | N_CPU+N_SRC | Per-pair output enable |
| free_run | input | N_CPU+N_SRC | Per-pair free-run select (ignores stop pins) |
| clk_t | output | N_CPU+N_SRC | True line of each pair |
| clk_c | output | N_CPU+N_SRC | Complement line of each pair |
| drv_en | output | N_CPU+N_SRC | Drive enable of each pair (0 = tristate) |
| out_state | output | 2*(N_CPU+N_SRC) | Per-pair state code, pair i in bits [2i+1:2i] |

## Verification
The delicate overlap is a stop release, together with configuration writes, landing while the power-down resume window is still running. Both the stop path and the resume counter then want to move the same pair at once. The bench provokes this by asserting a processor stop before power-down, releasing power-down, and a few cycles later releasing the stop, clearing one pair's enable and flipping a mode bit. It judges the result by showing that every pair holds its latched power-down state until RESUME_CYC cycles have passed, and that within a few cycles after that each pair shows the state the new inputs imply.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
  typedef enum logic [1:0] {
    ST_RUN = 2'b00,
    ST_DRV = 2'b01,
    ST_TRI = 2'b10
  } pair_state_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W       = 1,
  parameter int STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= {W{RST_VAL}};
    end else begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/resume_timer.sv
module resume_timer #(
  parameter int RESUME_CYC = 360000,
  localparam int CW = $clog2(RESUME_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_req,
  output logic busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (pd_req)     cnt <= CW'(RESUME_CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = pd_req | (cnt != '0);

  // R8: a power-down release keeps the window open
  a_r8_hold_on_release: assert property (@(posedge clk) disable iff (rst)
    $fell(pd_req) |-> busy);

  // R8: counter never overshoots the window length
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(RESUME_CYC));
endmodule

// File: rtl/pair_gate.sv
module pair_gate
  import clk_stop_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ph,
  input  logic       oe,
  input  logic       free,
  input  logic       stop_req,
  input  logic       stop_tri,
  input  logic       pd_hold,
  input  logic       pd_tri,
  output logic       clk_t,
  output logic       clk_c,
  output logic       drv_en,
  output logic [1:0] state
);
  pair_state_e st, want, nst;
  logic upd, ph_n;

  assign ph_n = ~ph;
  assign upd  = ~ph;

  always_comb begin
    if (!oe)                  want = ST_TRI;
    else if (pd_hold)         want = pd_tri ? ST_TRI : ST_DRV;
    else if (stop_req && !free) want = stop_tri ? ST_TRI : ST_DRV;
    else                      want = ST_RUN;
    nst = upd ? want : st;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_TRI;
      clk_t  <= 1'b0;
      clk_c  <= 1'b0;
      drv_en <= 1'b0;
    end else begin
      st <= nst;
      unique case (nst)
        ST_RUN: begin clk_t <= ph_n; clk_c <= ~ph_n; drv_en <= 1'b1; end
        ST_DRV: begin clk_t <= 1'b1; clk_c <= 1'b0;  drv_en <= 1'b1; end
        default: begin clk_t <= 1'b0; clk_c <= 1'b0; drv_en <= 1'b0; end
      endcase
    end
  end

  assign state = st;

  // R10: state moves only on the edge where the true line would rise
  a_r10_gate_on_rise: assert property (@(posedge clk) disable iff (rst)
    !$stable(st) |-> ph);

  // R3: an undriven pair leaves both lines low
  a_r3_tri_lines_low: assert property (@(posedge clk) disable iff (rst)
    !drv_en |-> (!clk_t && !clk_c));

  // R4: a parked pair holds true high and complement low
  a_r4_park_levels: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DRV) |-> (clk_t && !clk_c && drv_en));
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
  import clk_stop_pkg::*;
#(
  parameter int N_CPU      = 2,
  parameter int N_SRC      = 2,
  parameter int RESUME_CYC = 360000,
  localparam int N = N_CPU + N_SRC
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cpu_stop_n,
  input  logic           pci_stop_n,
  input  logic           pwrdn_n,
  input  logic           cpu_stop_tri,
  input  logic           cpu_pd_tri,
  input  logic           src_stop_tri,
  input  logic           src_pd_tri,
  input  logic [N-1:0]   out_oe,
  input  logic [N-1:0]   free_run,
  output logic [N-1:0]   clk_t,
  output logic [N-1:0]   clk_c,
  output logic [N-1:0]   drv_en,
  output logic [2*N-1:0] out_state
);
  logic [2:0] pins_s;
  logic cpu_stop_req, pci_stop_req, pd_req, busy;
  logic ph;

  pin_sync #(.W(3), .STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({pwrdn_n, pci_stop_n, cpu_stop_n}),
    .dout(pins_s)
  );

  assign cpu_stop_req = ~pins_s[0];
  assign pci_stop_req = ~pins_s[1];
  assign pd_req       = ~pins_s[2];

  resume_timer #(.RESUME_CYC(RESUME_CYC)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .pd_req(pd_req),
    .busy  (busy)
  );

  // configuration is frozen while power-down or its resume window is active
  logic [3:0]   mode_q, mode_in, mode_eff;
  logic [N-1:0] oe_q, oe_eff, free_q, free_eff;

  assign mode_in  = {src_pd_tri, src_stop_tri, cpu_pd_tri, cpu_stop_tri};
  assign mode_eff = busy ? mode_q : mode_in;
  assign oe_eff   = busy ? oe_q   : out_oe;
  assign free_eff = busy ? free_q : free_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      oe_q   <= '0;
      free_q <= '0;
      ph     <= 1'b0;
    end else begin
      mode_q <= mode_eff;
      oe_q   <= oe_eff;
      free_q <= free_eff;
      ph     <= ~ph;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_pair
    logic g_stop, g_stop_tri, g_pd_tri;
    if (i < N_CPU) begin : g_cpu
      assign g_stop     = cpu_stop_req;
      assign g_stop_tri = mode_eff[0];
      assign g_pd_tri   = mode_eff[1];
    end else begin : g_src
      assign g_stop     = pci_stop_req;
      assign g_stop_tri = mode_eff[2];
      assign g_pd_tri   = mode_eff[3];
    end

    pair_gate u_pair (
      .clk     (clk),
      .rst     (rst),
      .ph      (ph),
      .oe      (oe_eff[i]),
      .free    (free_eff[i]),
      .stop_req(g_stop),
      .stop_tri(g_stop_tri),
      .pd_hold (busy),
      .pd_tri  (g_pd_tri),
      .clk_t   (clk_t[i]),
      .clk_c   (clk_c[i]),
      .drv_en  (drv_en[i]),
      .state   (out_state[2*i +: 2])
    );
  end
endmodule

// File: tb/tb_clk_stop_gate.sv
module tb_clk_stop_gate;
  localparam int N_CPU = 2;
  localparam int N_SRC = 2;
  localparam int N     = N_CPU + N_SRC;
  localparam int RES   = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwrdn_n = 1'b1;
  logic cpu_stop_tri = 1'b0, cpu_pd_tri = 1'b0, src_stop_tri = 1'b0, src_pd_tri = 1'b0;
  logic [N-1:0] out_oe = '1;
  logic [N-1:0] free_run = 4'b1010;
  logic [N-1:0] clk_t, clk_c, drv_en;
  logic [2*N-1:0] out_state;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  clk_stop_gate #(.N_CPU(N_CPU), .N_SRC(N_SRC), .RESUME_CYC(RES)) dut (.*);

  task automatic wait_neg(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [1:0] got, logic [1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic chk_state(string tag, int i, logic [1:0] exp);
    chk(tag, out_state[2*i +: 2], exp);
  endtask

  task automatic t_reset;
    wait_neg(3);
    for (int i = 0; i < N; i++) begin
      chk_state("R1 reset state", i, 2'b10);
      chk("R1 reset drive enable", {1'b0, drv_en[i]}, 2'b00);
    end
    rst = 1'b0;
    wait_neg(8);
  endtask

  task automatic t_run;
    logic a;
    for (int i = 0; i < N; i++) begin
      chk_state("R2 running state", i, 2'b00);
      chk("R2 running enable", {1'b0, drv_en[i]}, 2'b01);
    end
    a = clk_t[0];
    chk("R2 complement", {clk_t[0], clk_c[0]}, {a, ~a});
    wait_neg(1);
    chk("R2 toggle", {clk_t[0], clk_c[0]}, {~a, a});
  endtask

  task automatic t_oe;
    out_oe[2] = 1'b0;
    wait_neg(6);
    chk_state("R3 disabled state", 2, 2'b10);
    chk("R3 disabled lines", {clk_t[2], clk_c[2]}, 2'b00);
    chk("R3 disabled enable", {1'b0, drv_en[2]}, 2'b00);
    out_oe[2] = 1'b1;
    wait_neg(6);
    chk_state("R3 re-enabled", 2, 2'b00);
  endtask

  task automatic t_stop_park;
    cpu_stop_n = 1'b0;
    wait_neg(4);
    chk_state("R11 R4 parked within 4 cycles", 0, 2'b01);
    chk("R4 parked levels", {clk_t[0], clk_c[0]}, 2'b10);
    chk_state("R4 free-running pair keeps running", 1, 2'b00);
    chk_state("R6 peripheral pair ignores processor stop", 2, 2'b00);
    chk_state("R6 peripheral free pair ignores processor stop", 3, 2'b00);
    cpu_stop_n = 1'b1;
    wait_neg(4);
    chk_state("R4 restart after stop release", 0, 2'b00);
  endtask

  task automatic t_stop_tri;
    cpu_stop_tri = 1'b1;
    src_stop_tri = 1'b1;
    pci_stop_n = 1'b0;
    wait_neg(4);
    chk_state("R5 R11 peripheral stop tristate", 2, 2'b10);
    chk_state("R5 free pair unaffected", 3, 2'b00);
    chk_state("R6 processor pair ignores peripheral stop", 0, 2'b00);
    pci_stop_n = 1'b1;
    cpu_stop_tri = 1'b0;
    src_stop_tri = 1'b0;
    wait_neg(6);
    chk_state("R5 restart after tristate stop", 2, 2'b00);
  endtask

  task automatic t_pd_resume;
    cpu_stop_n = 1'b0;
    cpu_pd_tri = 1'b1;
    src_pd_tri = 1'b0;
    wait_neg(6);
    pwrdn_n = 1'b0;
    wait_neg(6);
    chk_state("R7 processor pair power-down tristate", 0, 2'b10);
    chk_state("R7 processor free pair power-down tristate", 1, 2'b10);
    chk_state("R7 peripheral pair power-down parked", 2, 2'b01);
    chk_state("R7 peripheral free pair power-down parked", 3, 2'b01);
    pwrdn_n = 1'b1;
    wait_neg(3);
    cpu_stop_n = 1'b1;
    out_oe[2]  = 1'b0;
    cpu_pd_tri = 1'b0;
    wait_neg(RES - 3);
    chk_state("R8 R9 pair 0 held through window", 0, 2'b10);
    chk_state("R9 mode change held back in window", 1, 2'b10);
    chk_state("R9 enable change held back in window", 2, 2'b01);
    chk_state("R8 pair 3 held through window", 3, 2'b01);
    wait_neg(6);
    chk_state("R9 stop release applied at window end", 0, 2'b00);
    chk_state("R8 free pair resumes", 1, 2'b00);
    chk_state("R9 enable change applied at window end", 2, 2'b10);
    chk_state("R8 peripheral pair resumes", 3, 2'b00);
    out_oe[2] = 1'b1;
  endtask

  initial begin
    t_reset();
    t_run();
    t_oe();
    t_stop_park();
    t_stop_tri();
    t_pd_resume();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule